// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit collects the event flags of a display refresh controller and turns them into one interrupt request. The rest of the controller sends it single-cycle strobes. These strobes report a pixel FIFO underrun, the hand-over of the base address into the current address at frame start, a vertical compare match, and the end of each frame. The unit also sees writes to the DMA base address register and to the controller enable bit. A small register bus lets software read the event flags and clear them by writing ones. Software can also program an enable mask and read the masked vector.

Each flag has its own rules for setting and clearing. The frame-done flag is deferred. When software turns the controller off, the unit holds it active until the end-of-frame strobe arrives. Only at that point does it report the controller idle and raise frame-done. A hardware set always beats a software clear that lands on the same cycle, so no event is lost.

Top module: `disp_irq_unit`

## Requirements
- R1: After reset the status register, the mask register, the interrupt register, `irq_o` and `ctl_active` all read 0.
- R2: The mask register at offset 0x4 is read/write in bits 3:0. Its bits 31:4 read 0.
- R3: The interrupt register at offset 0x8 reads as status AND mask in bits 3:0, with bits 31:4 at 0. Writes to 0x8 change neither status nor mask, and an unmapped offset such as 0xC reads 0.
- R4: `irq_o` is 1 exactly when the interrupt register was nonzero in the previous cycle.
- R5: Status bit 0 (underflow) sets on `ev_underrun`. It stays set until a status write at offset 0x0 has data bit 0 at 1.
- R6: Status bit 2 (vertical compare) sets on `ev_vcomp`. It stays set until a status write has data bit 2 at 1.
- R7: Status bit 1 (next base taken) sets on `ev_base_xfer`. It clears on `base_wr` or on a status write with data bit 1 at 1. A `base_wr` leaves bits 0 and 2 unchanged.
- R8: In a status write, a data bit of 0 leaves its status bit unchanged. No status write ever sets a bit.
- R9: If a set event and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R10: An enable write with value 1 makes `ctl_active` 1 in the next cycle. An enable write with value 0 while active keeps `ctl_active` at 1 until the next `ev_frame_end`. At that edge `ctl_active` drops to 0 and status bit 3 (frame done) sets.
- R11: Status bit 3 clears on `base_wr`, on an enable write with value 1, or on a status write with data bit 3 at 1.
- R12: `ev_frame_end` with no disable pending changes neither `ctl_active` nor status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from bus_addr) |
| base_wr | input | 1 | Strobe: software wrote the DMA base address register |
| en_wr | input | 1 | Strobe: software wrote the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| ev_underrun | input | 1 | Strobe: pixel FIFO underrun |
| ev_base_xfer | input | 1 | Strobe: base address moved to current address |
| ev_vcomp | input | 1 | Strobe: vertical compare match |
| ev_frame_end | input | 1 | Strobe: last pixels of a frame clocked out |
| irq_o | output | 1 | Registered interrupt request |
| ctl_active | output | 1 | Controller still running |

## Verification
The bench builds the unit with its defaults: a 4-bit address and a 32-bit data bus over a 4-bit event vector. With only four flags, every status pattern can be combined with all 16 mask values and with all 16 clear patterns. This covers the masked vector, the registered request and write-one-to-clear in full. Directed sequences cover the deferred disable and the collisions between set and clear.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
    localparam int NUM_EV  = 4;
    localparam int B_UFLOW = 0;
    localparam int B_NEXT  = 1;
    localparam int B_VCMP  = 2;
    localparam int B_DONE  = 3;
    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/disp_irq_track.sv
module disp_irq_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_val,
    input  logic frame_end,
    output logic active,
    output logic done_set
);
    typedef struct packed {
        logic active;
        logic pend;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d    = trk_q;
        done_set = 1'b0;
        if (en_wr && en_val) begin
            trk_d.active = 1'b1;
            trk_d.pend   = 1'b0;
        end else begin
            if (frame_end && trk_q.pend) begin
                trk_d.active = 1'b0;
                trk_d.pend   = 1'b0;
                done_set     = 1'b1;
            end
            if (en_wr && !en_val && trk_q.active && !(frame_end && trk_q.pend)) begin
                trk_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign active = trk_q.active;

    AST_PEND_IMPLIES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.pend |-> trk_q.active); // R10
    AST_DROP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trk_q.active) |-> ($past(frame_end) && $past(trk_q.pend))); // R10
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
    import disp_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ev_vec_t set_vec,
    input  ev_vec_t clr_vec,
    output ev_vec_t stat
);
    typedef struct packed {
        ev_vec_t stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> stat[i]); // R9
        AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !$past(stat[i])) |-> $past(set_vec[i])); // R8
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !clr_vec[i]) |=> stat[i]); // R5
    end
endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
    import disp_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mask_we,
    input  ev_vec_t mask_wdata,
    input  ev_vec_t stat,
    output ev_vec_t mask,
    output ev_vec_t int_vec,
    output logic    irq
);
    typedef struct packed {
        ev_vec_t mask;
        logic    irq;
    } rg_t;

    rg_t rg_d, rg_q;

    always_comb begin
        rg_d     = rg_q;
        int_vec  = rg_q.mask & stat;
        rg_d.irq = |int_vec;
        if (mask_we) rg_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign mask = rg_q.mask;
    assign irq  = rg_q.irq;

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(rg_q.mask)); // R2
endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
    import disp_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFF_STAT = 'h0,
    parameter logic [ADDR_W-1:0] OFF_MASK = 'h4,
    parameter logic [ADDR_W-1:0] OFF_INT  = 'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              base_wr,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              ev_underrun,
    input  logic              ev_base_xfer,
    input  logic              ev_vcomp,
    input  logic              ev_frame_end,
    output logic              irq_o,
    output logic              ctl_active
);
    localparam int PAD_W = DATA_W - NUM_EV;

    ev_vec_t set_vec, clr_vec, stat, mask, int_vec, wd;
    logic    done_set, wr_stat, wr_mask;
    logic    wdata_unused;

    assign wd           = bus_wdata[NUM_EV-1:0];
    assign wdata_unused = ^bus_wdata[DATA_W-1:NUM_EV];
    assign wr_stat      = bus_sel && bus_wr && (bus_addr == OFF_STAT);
    assign wr_mask      = bus_sel && bus_wr && (bus_addr == OFF_MASK);

    always_comb begin
        set_vec          = '0;
        set_vec[B_UFLOW] = ev_underrun;
        set_vec[B_NEXT]  = ev_base_xfer;
        set_vec[B_VCMP]  = ev_vcomp;
        set_vec[B_DONE]  = done_set;
        clr_vec          = wr_stat ? wd : '0;
        clr_vec[B_NEXT]  = clr_vec[B_NEXT] | base_wr;
        clr_vec[B_DONE]  = clr_vec[B_DONE] | base_wr | (en_wr && en_val);
    end

    always_comb begin
        case (bus_addr)
            OFF_STAT: bus_rdata = {{PAD_W{1'b0}}, stat};
            OFF_MASK: bus_rdata = {{PAD_W{1'b0}}, mask};
            OFF_INT:  bus_rdata = {{PAD_W{1'b0}}, int_vec};
            default:  bus_rdata = '0;
        endcase
    end

    disp_irq_track u_track (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
        .frame_end(ev_frame_end), .active(ctl_active), .done_set(done_set)
    );

    disp_irq_status u_status (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .stat(stat)
    );

    disp_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .mask_we(wr_mask), .mask_wdata(wd),
        .stat(stat), .mask(mask), .int_vec(int_vec), .irq(irq_o)
    );

    AST_IRQ_LAGS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |($past(stat) & $past(mask))); // R4
    AST_FALL_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_active) |-> stat[B_DONE]); // R10
    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ((base_wr || (en_wr && en_val)) && !done_set) |=> !stat[B_DONE]); // R11
    AST_NEXT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !ev_base_xfer) |=> !stat[B_NEXT]); // R7
    AST_VCMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[B_VCMP] && !(wr_stat && wd[B_VCMP])) |=> stat[B_VCMP]); // R6
    AST_INT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFF_INT) |=> $stable(mask)); // R3
endmodule

// File: tb/disp_irq_unit_test.sv
module disp_irq_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        base_wr = 1'b0, en_wr = 1'b0, en_val = 1'b0;
    logic        ev_underrun = 1'b0, ev_base_xfer = 1'b0, ev_vcomp = 1'b0, ev_frame_end = 1'b0;
    logic        irq_o, ctl_active;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .base_wr(base_wr), .en_wr(en_wr), .en_val(en_val),
        .ev_underrun(ev_underrun), .ev_base_xfer(ev_base_xfer),
        .ev_vcomp(ev_vcomp), .ev_frame_end(ev_frame_end),
        .irq_o(irq_o), .ctl_active(ctl_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // one cycle of strobes: {underrun, base_xfer, vcomp, frame_end, base_wr, en_wr, en_val}
    task automatic strobe(input logic uf, input logic bx, input logic vc, input logic fe,
                          input logic bw, input logic ew, input logic ev);
        @(negedge clk);
        ev_underrun = uf; ev_base_xfer = bx; ev_vcomp = vc; ev_frame_end = fe;
        base_wr = bw; en_wr = ew; en_val = ev;
        @(negedge clk);
        ev_underrun = 0; ev_base_xfer = 0; ev_vcomp = 0; ev_frame_end = 0;
        base_wr = 0; en_wr = 0; en_val = 0;
    endtask

    task automatic make_status(input logic [3:0] s);
        wr(4'h0, 32'hF);
        if (s[3]) begin
            strobe(0, 0, 0, 0, 0, 1, 1);
            strobe(0, 0, 0, 0, 0, 1, 0);
            strobe(0, 0, 0, 1, 0, 0, 0);
        end
        strobe(s[0], s[1], s[2], 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, d); check("R1 status", d, 0);
        rd(4'h4, d); check("R1 mask", d, 0);
        rd(4'h8, d); check("R1 int", d, 0);
        check("R1 irq_o", {31'b0, irq_o}, 0);
        check("R1 active", {31'b0, ctl_active}, 0);

        // R2 mask width
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R2 mask upper zero", d, 32'hF);
        wr(4'h4, 32'h5);
        rd(4'h4, d); check("R2 mask rw", d, 32'h5);

        // R3 R4 R5 R6 R7 R10 sweep of status x mask
        for (int s = 0; s < 16; s++) begin
            make_status(s[3:0]);
            rd(4'h0, d); check("R5 R6 R7 R10 status pattern", d, s);
            for (int m = 0; m < 16; m++) begin
                wr(4'h4, 32'hABCD_EF00 | m);
                rd(4'h4, d); check("R2 mask readback", d, m);
                rd(4'h8, d); check("R3 int vector", d, s & m);
                @(negedge clk);
                check("R4 irq_o", {31'b0, irq_o}, ((s & m) != 0) ? 1 : 0);
            end
        end

        // R3 write to int register ignored, unmapped reads zero
        make_status(4'hF);
        wr(4'h4, 32'h3);
        wr(4'h8, 32'h0);
        rd(4'h4, d); check("R3 int write leaves mask", d, 32'h3);
        wr(4'h8, 32'hF);
        rd(4'h0, d); check("R3 int write leaves status", d, 32'hF);
        rd(4'hC, d); check("R3 unmapped read", d, 0);

        // R5 R6 R8 write-one-to-clear sweep
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 16; w++) begin
                make_status(s[3:0]);
                wr(4'h0, 32'hFFFF_FFF0 | w);
                rd(4'h0, d); check("R8 w1c result", d, s & ~w & 4'hF);
            end
        end

        // R5 R6 sticky after events end
        make_status(4'h5);
        repeat (5) @(negedge clk);
        rd(4'h0, d); check("R5 R6 sticky", d, 32'h5);

        // R7 base write clears bit1 and bit3 only
        make_status(4'hF);
        strobe(0, 0, 0, 0, 1, 0, 0);
        rd(4'h0, d); check("R7 base write clear", d, 32'h5);

        // R11 enable write 1 clears bit3 only
        make_status(4'hF);
        strobe(0, 0, 0, 0, 0, 1, 1);
        rd(4'h0, d); check("R11 enable clears done", d, 32'h7);
        check("R10 enable sets active", {31'b0, ctl_active}, 1);

        // R12 frame end with no disable pending
        wr(4'h0, 32'hF);
        strobe(0, 0, 0, 1, 0, 0, 0);
        check("R12 active kept", {31'b0, ctl_active}, 1);
        rd(4'h0, d); check("R12 no done", d, 0);

        // R10 deferred disable
        strobe(0, 0, 0, 0, 0, 1, 0);
        check("R10 active while pending", {31'b0, ctl_active}, 1);
        rd(4'h0, d); check("R10 done not yet", d, 0);
        repeat (4) @(negedge clk);
        check("R10 still active", {31'b0, ctl_active}, 1);
        strobe(0, 0, 0, 1, 0, 0, 0);
        check("R10 inactive after end", {31'b0, ctl_active}, 0);
        rd(4'h0, d); check("R10 done set", d, 32'h8);

        // R12 disable write while idle, then frame end
        wr(4'h0, 32'hF);
        strobe(0, 0, 0, 0, 0, 1, 0);
        strobe(0, 0, 0, 1, 0, 0, 0);
        rd(4'h0, d); check("R12 idle frame end", d, 0);
        check("R12 idle stays idle", {31'b0, ctl_active}, 0);

        // R9 set wins over w1c, bit0
        wr(4'h0, 32'hF);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 32'h1; ev_underrun = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; ev_underrun = 0;
        rd(4'h0, d); check("R9 set beats w1c", d, 32'h1);

        // R9 base_xfer beats base_wr, bit1
        wr(4'h0, 32'hF);
        strobe(0, 1, 0, 0, 1, 0, 0);
        rd(4'h0, d); check("R9 xfer beats base write", d, 32'h2);

        // R9 frame done beats base write
        wr(4'h0, 32'hF);
        strobe(0, 0, 0, 0, 0, 1, 1);
        strobe(0, 0, 0, 0, 0, 1, 0);
        strobe(0, 0, 0, 1, 1, 0, 0);
        rd(4'h0, d); check("R9 done beats base write", d, 32'h8);

        ended = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule